// File: doc/BRIEF.md
# Trace Buffer Register Scan Port

This block is the test-port side of an on-chip trace buffer. It decodes a 4-bit instruction register and a small set of data registers. A host reaches the buffer's configuration and its captured trace words through scans. The TAP state machine sits outside the block. It presents single-cycle capture, shift and update strobes for the instruction and data paths, plus the serial input. The block returns the serial output.

One access scan is 40 bits wide. It carries a 32-bit data word, a 7-bit register address and a direction bit. At the update strobe a write is applied to the addressed register, or a read is carried out and its result held. The next scan loads that held result at its capture strobe and shifts it out. So every scan both starts a new access and returns the previous read. A read of the RAM data window returns the word at the RAM read pointer and advances the pointer. A read of the identification register has no side effect, so it is the usual last scan of a burst. A separate instruction selects a scan-chain number, and register access works only while chain 0 is selected.

The register map is: 0 identification (read-only), 1 RAM depth (read-only), 2 RAM word width (read-only), 3 status input (read-only), 4 RAM data window (read-only), 5 RAM read pointer, 6 write pointer, 7 trigger count, 8 control (all read/write). Every other address is unmapped.

Top module: `trace_reg_port`

## Requirements
- R1: While `rst_n` is low, the instruction becomes bypass (4'hF), the chain number becomes 0, the held read result becomes 0, and the read/write registers clear, so `ram_addr_o`, `wr_ptr_o`, `trig_cnt_o`, `ctrl_o` and `tdo` are all 0.
- R2: `capture_ir` loads 4'b0001 into the instruction shifter. Each `shift_ir` moves one bit in from `tdi`, least significant bit first, and shows the current bit 0 on `tdo`. `update_ir` makes the shifted value the active instruction.
- R3: Under instruction 4'hC the data path is a 40-bit shifter, shifted least significant bit first. Bits 31:0 hold the data, bits 38:32 the address, and bit 39 the direction (1 = write, 0 = read). A bit entering on `tdi` leaves on `tdo` 40 shifts later. `tdo` is 0 in any cycle without a shift strobe.
- R4: An update with direction 1 at addresses 5, 6, 7 or 8 loads the low bits of the data field into the read pointer, the write pointer, the trigger count or the control register. The new value appears on the matching output in the cycle after the update.
- R5: An update with direction 0 stores the addressed register's value as the held result. The next capture under 4'hC loads that result into bits 31:0 and zero into bits 39:32. A write leaves the held result unchanged.
- R6: A read of address 4 returns `ram_rdata_i` for the current `ram_addr_o`. It then advances the read pointer by one, wrapping from RAM_DEPTH-1 to 0.
- R7: A read of address 0 returns the constant ID_VALUE and changes no register.
- R8: Writes to addresses 0 to 4 and to unmapped addresses (9 to 127) change nothing. Reads of unmapped addresses return 0.
- R9: Instruction 4'h2 selects a 4-bit chain-number shifter. Its capture loads the current chain number and its update replaces it. While the chain number is not 0, an access capture loads all zeros and an access update does nothing.
- R10: Every instruction other than 4'hC and 4'h2 selects a one-bit bypass stage. Its capture loads 0, and it delays `tdi` to `tdo` by one shift.
- R11: Address 1 reads RAM_DEPTH, address 2 reads 32, and address 3 reads `status_i` zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| capture_ir | input | 1 | Instruction capture strobe |
| shift_ir | input | 1 | Instruction shift strobe |
| update_ir | input | 1 | Instruction update strobe |
| capture_dr | input | 1 | Data-register capture strobe |
| shift_dr | input | 1 | Data-register shift strobe |
| update_dr | input | 1 | Data-register update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| status_i | input | STAT_W | Trace status flags, readable at address 3 |
| ram_rdata_i | input | 32 | Trace RAM word at `ram_addr_o` |
| ram_addr_o | output | log2(RAM_DEPTH) | RAM read pointer |
| wr_ptr_o | output | log2(RAM_DEPTH) | Write pointer register |
| trig_cnt_o | output | log2(RAM_DEPTH) | Trigger count register |
| ctrl_o | output | CTRL_W | Control register |

## Verification
Register outputs change on the update strobe's clock edge. The bench samples them at the falling edge that follows. A read result is not due until the capture of the next access scan, one full scan later. The bench therefore checks each scan's data field against the model's result from the scan before, and applies that scan's own effect to the model only after the check. Serial output is sampled half a cycle before each shift edge, so bit i of the returned vector is the shifter's bit 0 before the i-th shift.

// File: rtl/trp_pkg.sv
package trp_pkg;
  localparam int IR_W   = 4;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 7;
  localparam int DR_W   = DATA_W + ADDR_W + 1;

  localparam logic [IR_W-1:0] IR_ACCESS  = 4'hC;
  localparam logic [IR_W-1:0] IR_CHAIN   = 4'h2;
  localparam logic [IR_W-1:0] IR_BYPASS  = 4'hF;
  localparam logic [IR_W-1:0] IR_CAP_VAL = 4'b0001;

  localparam logic [ADDR_W-1:0] A_IDENT   = 7'd0;
  localparam logic [ADDR_W-1:0] A_DEPTH   = 7'd1;
  localparam logic [ADDR_W-1:0] A_WIDTH   = 7'd2;
  localparam logic [ADDR_W-1:0] A_STATUS  = 7'd3;
  localparam logic [ADDR_W-1:0] A_RAMWIN  = 7'd4;
  localparam logic [ADDR_W-1:0] A_RDPTR   = 7'd5;
  localparam logic [ADDR_W-1:0] A_WRPTR   = 7'd6;
  localparam logic [ADDR_W-1:0] A_TRIG    = 7'd7;
  localparam logic [ADDR_W-1:0] A_CTRL    = 7'd8;

  typedef struct packed {
    logic              is_write;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } acc_word_t;

  typedef enum logic [1:0] {
    SEL_BYPASS = 2'd0,
    SEL_ACCESS = 2'd1,
    SEL_CHAIN  = 2'd2
  } dr_sel_e;
endpackage

// File: rtl/trp_ir_ctrl.sv
module trp_ir_ctrl
  import trp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture_ir,
  input  logic            shift_ir,
  input  logic            update_ir,
  input  logic            tdi,
  output logic            ir_tdo,
  output dr_sel_e         dr_sel
);
  logic [IR_W-1:0] sh_q, sh_d;
  logic [IR_W-1:0] ir_q, ir_d;

  always_comb begin
    sh_d = sh_q;
    if (capture_ir)    sh_d = IR_CAP_VAL;
    else if (shift_ir) sh_d = {tdi, sh_q[IR_W-1:1]};
  end

  always_comb begin
    ir_d = ir_q;
    if (update_ir) ir_d = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= IR_CAP_VAL;
      ir_q <= IR_BYPASS;
    end else begin
      sh_q <= sh_d;
      ir_q <= ir_d;
    end
  end

  always_comb begin
    case (ir_q)
      IR_ACCESS: dr_sel = SEL_ACCESS;
      IR_CHAIN:  dr_sel = SEL_CHAIN;
      default:   dr_sel = SEL_BYPASS;
    endcase
  end

  assign ir_tdo = sh_q[0];

  AST_IR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    capture_ir |=> sh_q == IR_CAP_VAL); // R2
  AST_IR_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (update_ir && !capture_ir && !shift_ir) |=> ir_q == $past(sh_q)); // R2
endmodule

// File: rtl/trp_scan_path.sv
module trp_scan_path
  import trp_pkg::*;
#(
  parameter int CHAIN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  input  dr_sel_e           dr_sel,
  input  logic [DATA_W-1:0] rd_result,
  output logic              dr_tdo,
  output logic              acc_valid,
  output acc_word_t         acc_word
);
  localparam logic [CHAIN_W-1:0] CHAIN_REG = '0;

  logic [DR_W-1:0]    acc_q, acc_d;
  logic [CHAIN_W-1:0] csh_q, csh_d;
  logic [CHAIN_W-1:0] chain_q, chain_d;
  logic               byp_q, byp_d;
  logic               sel_acc, sel_chn, sel_byp, chain_ok;

  assign sel_acc  = (dr_sel == SEL_ACCESS);
  assign sel_chn  = (dr_sel == SEL_CHAIN);
  assign sel_byp  = (dr_sel == SEL_BYPASS);
  assign chain_ok = (chain_q == CHAIN_REG);

  always_comb begin
    acc_d = acc_q;
    if (sel_acc && capture_dr) begin
      acc_d = chain_ok ? {{(ADDR_W+1){1'b0}}, rd_result} : '0;
    end else if (sel_acc && shift_dr) begin
      acc_d = {tdi, acc_q[DR_W-1:1]};
    end
  end

  always_comb begin
    csh_d   = csh_q;
    chain_d = chain_q;
    if (sel_chn && capture_dr)    csh_d = chain_q;
    else if (sel_chn && shift_dr) csh_d = {tdi, csh_q[CHAIN_W-1:1]};
    if (sel_chn && update_dr)     chain_d = csh_q;
  end

  always_comb begin
    byp_d = byp_q;
    if (sel_byp && capture_dr)    byp_d = 1'b0;
    else if (sel_byp && shift_dr) byp_d = tdi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      csh_q   <= '0;
      chain_q <= '0;
      byp_q   <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      csh_q   <= csh_d;
      chain_q <= chain_d;
      byp_q   <= byp_d;
    end
  end

  always_comb begin
    case (dr_sel)
      SEL_ACCESS: dr_tdo = acc_q[0];
      SEL_CHAIN:  dr_tdo = csh_q[0];
      default:    dr_tdo = byp_q;
    endcase
  end

  assign acc_valid = update_dr && sel_acc && chain_ok;
  assign acc_word  = acc_word_t'(acc_q);

  AST_CAPTURE_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_dr && sel_acc) |=> acc_q[DR_W-1:DATA_W] == '0); // R5
  AST_CHAIN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_dr && sel_acc && !chain_ok) |=> acc_q == '0); // R9
  AST_BYPASS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_dr && sel_byp) |=> byp_q == 1'b0); // R10
  AST_ACC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_dr && sel_acc && !capture_dr) |=> acc_q[DR_W-2:0] == $past(acc_q[DR_W-1:1])); // R3
endmodule

// File: rtl/trp_reg_bank.sv
module trp_reg_bank
  import trp_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_VALUE  = 32'h1B2C_0001,
  parameter int                RAM_DEPTH = 16,
  parameter int                CTRL_W    = 2,
  parameter int                STAT_W    = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         acc_valid,
  input  acc_word_t                    acc_word,
  input  logic [STAT_W-1:0]            status_i,
  input  logic [DATA_W-1:0]            ram_rdata_i,
  output logic [DATA_W-1:0]            rd_result,
  output logic [$clog2(RAM_DEPTH)-1:0] rd_ptr_o,
  output logic [$clog2(RAM_DEPTH)-1:0] wr_ptr_o,
  output logic [$clog2(RAM_DEPTH)-1:0] trig_o,
  output logic [CTRL_W-1:0]            ctrl_o
);
  localparam int PTR_W = $clog2(RAM_DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(RAM_DEPTH - 1);

  logic [PTR_W-1:0]  rdp_q, rdp_d, wrp_q, wrp_d, trig_q, trig_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] res_q, res_d, rd_mux;
  logic              do_wr, do_rd;

  assign do_wr = acc_valid && acc_word.is_write;
  assign do_rd = acc_valid && !acc_word.is_write;

  always_comb begin
    case (acc_word.addr)
      A_IDENT:  rd_mux = ID_VALUE;
      A_DEPTH:  rd_mux = DATA_W'(RAM_DEPTH);
      A_WIDTH:  rd_mux = DATA_W'(DATA_W);
      A_STATUS: rd_mux = DATA_W'(status_i);
      A_RAMWIN: rd_mux = ram_rdata_i;
      A_RDPTR:  rd_mux = DATA_W'(rdp_q);
      A_WRPTR:  rd_mux = DATA_W'(wrp_q);
      A_TRIG:   rd_mux = DATA_W'(trig_q);
      A_CTRL:   rd_mux = DATA_W'(ctrl_q);
      default:  rd_mux = '0;
    endcase
  end

  always_comb begin
    res_d  = res_q;
    rdp_d  = rdp_q;
    wrp_d  = wrp_q;
    trig_d = trig_q;
    ctrl_d = ctrl_q;
    if (do_rd) begin
      res_d = rd_mux;
      if (acc_word.addr == A_RAMWIN) begin
        rdp_d = (rdp_q == PTR_LAST) ? '0 : rdp_q + 1'b1;
      end
    end
    if (do_wr) begin
      case (acc_word.addr)
        A_RDPTR: rdp_d  = acc_word.data[PTR_W-1:0];
        A_WRPTR: wrp_d  = acc_word.data[PTR_W-1:0];
        A_TRIG:  trig_d = acc_word.data[PTR_W-1:0];
        A_CTRL:  ctrl_d = acc_word.data[CTRL_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      rdp_q  <= '0;
      wrp_q  <= '0;
      trig_q <= '0;
      ctrl_q <= '0;
    end else begin
      res_q  <= res_d;
      rdp_q  <= rdp_d;
      wrp_q  <= wrp_d;
      trig_q <= trig_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign rd_result = res_q;
  assign rd_ptr_o  = rdp_q;
  assign wr_ptr_o  = wrp_q;
  assign trig_o    = trig_q;
  assign ctrl_o    = ctrl_q;

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rd && acc_word.addr == A_RAMWIN) |=>
      rdp_q == (($past(rdp_q) == PTR_LAST) ? '0 : $past(rdp_q) + 1'b1)); // R6
  AST_IDENT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rd && acc_word.addr == A_IDENT) |=> (res_q == ID_VALUE) && $stable(rdp_q)); // R7
  AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && (acc_word.addr <= A_RAMWIN || acc_word.addr > A_CTRL)) |=>
      $stable({rdp_q, wrp_q, trig_q, ctrl_q})); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rd && acc_word.addr > A_CTRL) |=> res_q == '0); // R8
  AST_WRITE_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr || !acc_valid) |=> $stable(res_q)); // R5
endmodule

// File: rtl/trace_reg_port.sv
module trace_reg_port
  import trp_pkg::*;
#(
  parameter logic [31:0] ID_VALUE  = 32'h1B2C_0001,
  parameter int          RAM_DEPTH = 16,
  parameter int          CHAIN_W   = 4,
  parameter int          CTRL_W    = 2,
  parameter int          STAT_W    = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         capture_ir,
  input  logic                         shift_ir,
  input  logic                         update_ir,
  input  logic                         capture_dr,
  input  logic                         shift_dr,
  input  logic                         update_dr,
  input  logic                         tdi,
  output logic                         tdo,
  input  logic [STAT_W-1:0]            status_i,
  input  logic [31:0]                  ram_rdata_i,
  output logic [$clog2(RAM_DEPTH)-1:0] ram_addr_o,
  output logic [$clog2(RAM_DEPTH)-1:0] wr_ptr_o,
  output logic [$clog2(RAM_DEPTH)-1:0] trig_cnt_o,
  output logic [CTRL_W-1:0]            ctrl_o
);
  dr_sel_e           dr_sel;
  logic              ir_tdo, dr_tdo, acc_valid;
  acc_word_t         acc_word;
  logic [DATA_W-1:0] rd_result;

  trp_ir_ctrl u_ir (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_ir (capture_ir),
    .shift_ir   (shift_ir),
    .update_ir  (update_ir),
    .tdi        (tdi),
    .ir_tdo     (ir_tdo),
    .dr_sel     (dr_sel)
  );

  trp_scan_path #(.CHAIN_W(CHAIN_W)) u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .tdi        (tdi),
    .dr_sel     (dr_sel),
    .rd_result  (rd_result),
    .dr_tdo     (dr_tdo),
    .acc_valid  (acc_valid),
    .acc_word   (acc_word)
  );

  trp_reg_bank #(
    .ID_VALUE  (ID_VALUE),
    .RAM_DEPTH (RAM_DEPTH),
    .CTRL_W    (CTRL_W),
    .STAT_W    (STAT_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_word    (acc_word),
    .status_i    (status_i),
    .ram_rdata_i (ram_rdata_i),
    .rd_result   (rd_result),
    .rd_ptr_o    (ram_addr_o),
    .wr_ptr_o    (wr_ptr_o),
    .trig_o      (trig_cnt_o),
    .ctrl_o      (ctrl_o)
  );

  always_comb begin
    if (shift_ir)      tdo = ir_tdo;
    else if (shift_dr) tdo = dr_tdo;
    else               tdo = 1'b0;
  end

  AST_TDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_ir || shift_dr) |-> tdo == 1'b0); // R3
  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_word.is_write && acc_word.addr == A_TRIG) |=>
      trig_cnt_o == $past(acc_word.data[$clog2(RAM_DEPTH)-1:0])); // R4
endmodule

// File: tb/tb_trace_reg_port.sv
`timescale 1ns/1ps
module tb_trace_reg_port;
  localparam logic [31:0] ID_VAL = 32'h1B2C_0001;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic capture_ir = 0, shift_ir = 0, update_ir = 0;
  logic capture_dr = 0, shift_dr = 0, update_dr = 0;
  logic tdi = 0;
  logic tdo;
  logic [3:0]  status_i = 4'h0;
  logic [31:0] ram_rdata_i;
  logic [3:0]  ram_addr_o, wr_ptr_o, trig_cnt_o;
  logic [1:0]  ctrl_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [3:0]  m_rdp = 0, m_wrp = 0, m_trig = 0;
  logic [1:0]  m_ctrl = 0;
  logic [31:0] m_res = 0;

  always #2 clk = ~clk;

  trace_reg_port #(.ID_VALUE(ID_VAL), .RAM_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n),
    .capture_ir(capture_ir), .shift_ir(shift_ir), .update_ir(update_ir),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .tdo(tdo), .status_i(status_i), .ram_rdata_i(ram_rdata_i),
    .ram_addr_o(ram_addr_o), .wr_ptr_o(wr_ptr_o),
    .trig_cnt_o(trig_cnt_o), .ctrl_o(ctrl_o)
  );

  function automatic logic [31:0] ram_word(input logic [3:0] a);
    return 32'hC0DE_0000 ^ {8{a}} ^ {a, 28'h0};
  endfunction
  assign ram_rdata_i = ram_word(ram_addr_o);

  function automatic logic [31:0] model_read(input logic [6:0] a);
    case (a)
      7'd0: return ID_VAL;
      7'd1: return 32'(DEPTH);
      7'd2: return 32'd32;
      7'd3: return {28'h0, status_i};
      7'd4: return ram_word(m_rdp);
      7'd5: return {28'h0, m_rdp};
      7'd6: return {28'h0, m_wrp};
      7'd7: return {28'h0, m_trig};
      7'd8: return {30'h0, m_ctrl};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic scan_ir(input logic [3:0] v, output logic [3:0] dout);
    capture_ir = 1; @(posedge clk); @(negedge clk); capture_ir = 0;
    for (int i = 0; i < 4; i++) begin
      shift_ir = 1; tdi = v[i]; #1; dout[i] = tdo;
      @(posedge clk); @(negedge clk);
    end
    shift_ir = 0; update_ir = 1; @(posedge clk); @(negedge clk); update_ir = 0;
  endtask

  task automatic set_ir(input logic [3:0] v);
    logic [3:0] o;
    scan_ir(v, o);
    chk("R2 ir capture", {76'h0, o}, {76'h0, 4'b0001});
  endtask

  task automatic scan_dr(input int n, input logic [79:0] din, output logic [79:0] dout);
    dout = '0;
    capture_dr = 1; @(posedge clk); @(negedge clk); capture_dr = 0;
    for (int i = 0; i < n; i++) begin
      shift_dr = 1; tdi = din[i]; #1; dout[i] = tdo;
      @(posedge clk); @(negedge clk);
    end
    shift_dr = 0; update_dr = 1; @(posedge clk); @(negedge clk); update_dr = 0;
  endtask

  task automatic apply_model(input logic w, input logic [6:0] a, input logic [31:0] d);
    if (w) begin
      case (a)
        7'd5: m_rdp = d[3:0];
        7'd6: m_wrp = d[3:0];
        7'd7: m_trig = d[3:0];
        7'd8: m_ctrl = d[1:0];
        default: ;
      endcase
    end else begin
      m_res = model_read(a);
      if (a == 7'd4) m_rdp = (m_rdp == 4'(DEPTH - 1)) ? 4'd0 : m_rdp + 4'd1;
    end
  endtask

  task automatic access(input string req, input logic w, input logic [6:0] a, input logic [31:0] d);
    logic [79:0] o;
    logic [31:0] prev;
    logic [31:0] pre_read;
    prev = m_res;
    pre_read = model_read(a);
    scan_dr(40, {40'h0, w, a, d}, o);
    chk({req, " R5 returned data"}, o, {48'h0, prev});
    apply_model(w, a, d);
    if (!w) m_res = pre_read;
    chk({req, " R4 outputs"}, {70'h0, ram_addr_o, wr_ptr_o, trig_cnt_o, ctrl_o},
        {70'h0, m_rdp, m_wrp, m_trig, m_ctrl});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    logic [79:0] o;
    logic [3:0]  io;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {66'h0, tdo, ram_addr_o, wr_ptr_o, trig_cnt_o, ctrl_o}, 80'h0);
    rst_n = 1;
    @(negedge clk);

    // R10 and R1: bypass after reset
    scan_dr(8, 80'hB6, o);
    chk("R10 bypass after reset", o, {72'h0, 8'hB6 << 1} & 80'hFF);

    set_ir(4'hC);
    access("R7 first", 1'b0, 7'd0, 32'h0);   // returns reset result 0 (R1)
    access("R11 depth", 1'b0, 7'd1, 32'h0);  // returns ID (R7)
    status_i = 4'hA;
    access("R11 width", 1'b0, 7'd2, 32'h0);
    access("R11 status", 1'b0, 7'd3, 32'h0);
    access("R11 tail", 1'b0, 7'd0, 32'h0);

    // R4 writes
    access("R4 trig", 1'b1, 7'd7, 32'hFFFF_FFF5);
    access("R4 wrp", 1'b1, 7'd6, 32'h9);
    access("R4 ctrl", 1'b1, 7'd8, 32'h3);
    access("R4 rdp", 1'b1, 7'd5, 32'hE);
    access("R4 readback", 1'b0, 7'd7, 32'h0);
    // R6 RAM window with wrap
    access("R6 ram0", 1'b0, 7'd4, 32'h0);
    access("R6 ram1", 1'b0, 7'd4, 32'h0);
    access("R6 ram2", 1'b0, 7'd4, 32'h0);
    access("R6 tail", 1'b0, 7'd0, 32'h0);
    chk("R6 pointer wrapped", {76'h0, ram_addr_o}, {76'h0, 4'd1});

    // R8 ignored writes
    for (int a = 0; a < 5; a++) access("R8 ro write", 1'b1, 7'(a), 32'hFFFF_FFFF);
    access("R8 unmapped write", 1'b1, 7'd9, 32'hFFFF_FFFF);
    access("R8 unmapped write hi", 1'b1, 7'h7F, 32'h1234_5678);
    access("R8 unmapped read", 1'b0, 7'h50, 32'h0);
    access("R8 ident intact", 1'b0, 7'd0, 32'h0);
    access("R8 depth intact", 1'b0, 7'd1, 32'h0);
    access("R8 tail", 1'b0, 7'd0, 32'h0);

    // R9 chain select
    set_ir(4'h2);
    scan_dr(4, 80'h5, o);
    chk("R9 chain capture", o & 80'hF, 80'h0);
    set_ir(4'hC);
    scan_dr(40, {40'h0, 1'b1, 7'd7, 32'hA}, o);
    chk("R9 blocked capture", o, 80'h0);
    chk("R9 blocked write", {76'h0, trig_cnt_o}, {76'h0, m_trig});
    set_ir(4'h2);
    scan_dr(4, 80'h0, o);
    chk("R9 chain readback", o & 80'hF, 80'h5);
    set_ir(4'hC);
    access("R9 restored", 1'b0, 7'd0, 32'h0);

    // R3 pass-through latency of 40 shifts
    scan_dr(80, {1'b0, 7'd0, 32'h0, 40'hA5_3C96_0F1E}, o);
    chk("R3 forty shift delay", {40'h0, o[79:40]}, {40'h0, 40'hA5_3C96_0F1E});
    chk("R3 captured first half", {40'h0, o[39:0]}, {48'h0, m_res});
    apply_model(1'b0, 7'd0, 32'h0);

    // random mix
    for (int k = 0; k < 200; k++) begin
      logic [6:0] a;
      int r;
      r = $urandom % 12;
      a = (r > 9) ? 7'($urandom) : 7'(r);
      status_i = 4'($urandom);
      access("R5 random", 1'($urandom), a, $urandom);
    end

    // R10 bypass under another code
    scan_ir(4'h7, io);
    chk("R2 ir capture", {76'h0, io}, {76'h0, 4'b0001});
    scan_dr(8, 80'h6D, o);
    chk("R10 bypass code 7", o, {72'h0, 8'hDA});
    chk("R3 tdo idle", {79'h0, tdo}, 80'h0);

    report();
  end
endmodule